// File: doc/BRIEF.md
# Rate-Matched Dual-Clock Circular Queue

This block carries a data word from a slow clock domain into a faster one through a small ring of storage. The slow side writes one word on every one of its cycles, with no enable and no back-pressure. The fast side moves its read position only on cycles where a qualifier input is high. An outside tracking circuit sets the qualifier so that, on average, the read position moves at the slow clock's rate. The distance between the write and read positions then stays constant. The two clocks may have any phase relationship, may differ in frequency by one or two percent, and the qualifier may follow an irregular pattern.

A one-cycle adjust command lets the tracking circuit nudge the read position. A skip moves it one entry further forward than its normal step. A slip moves it one entry back. After reset the read position sits a fixed, parameter-chosen number of entries behind the write position, so the reader starts on entries that are well clear of the writer. The read data and the read position are the outputs; the data path has no valid or ready signalling.

Top module: `rate_fifo`

## Requirements
- R1: While the read-side reset is asserted, and until the first fast edge after it is released, `rd_pos` equals DEPTH-OFFSET (4 with the defaults DEPTH=8, OFFSET=4) and `rd_data` is zero.
- R2: After write-side reset release, every slow clock edge stores `wr_data` into the next entry. The first edge writes entry 0, and the entry index wraps from DEPTH-1 to 0.
- R3: On a fast edge with `rd_step`=1 and `rd_adj`=2'b00, `rd_pos` advances by one entry, wrapping from DEPTH-1 to 0.
- R4: On a fast edge with `rd_step`=0 and `rd_adj`=2'b00, `rd_pos` is unchanged.
- R5: `rd_adj`=2'b01 (skip) adds one entry to the normal step: +2 with `rd_step`=1, +1 with `rd_step`=0, modulo DEPTH.
- R6: `rd_adj`=2'b10 (slip) takes one entry from the normal step: +0 with `rd_step`=1, -1 with `rd_step`=0, so 0 wraps to DEPTH-1.
- R7: `rd_adj`=2'b11 has no effect; the position moves exactly as with 2'b00.
- R8: After each fast edge, `rd_data` holds the word most recently stored in the entry now addressed by `rd_pos`, for regular and irregular `rd_step` patterns, provided the two positions are not equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Slow, free-running write clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write side |
| wr_data | input | WIDTH | Word stored on every write clock edge |
| rd_clk | input | 1 | Fast read clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read side |
| rd_step | input | 1 | Qualifier: advance the read position this cycle |
| rd_adj | input | 2 | Position adjust: 00 none, 01 skip, 10 slip, 11 none |
| rd_data | output | WIDTH | Word at the current read position |
| rd_pos | output | $clog2(DEPTH) | Current read position |

## Verification
On every fast cycle, properties check the read position arithmetic: the reset placement, the plain step and hold, skip and slip with and without a step, and the ignored adjust code. What the storage returns cannot be seen from the read-side ports alone. So the bench's scenarios must show that writes land in order and wrap, and that the word read back belongs to the addressed entry. They drive an exact 3:2 clock ratio, a regular and an irregular qualifier pattern, and adjust commands at the wrap point.

// File: rtl/rate_fifo_pkg.sv
package rate_fifo_pkg;

   // read position adjust codes; the field sits on port rd_adj
   typedef enum logic [1:0] {
      ADJ_NONE = 2'b00,
      ADJ_SKIP = 2'b01,
      ADJ_SLIP = 2'b10,
      ADJ_RSVD = 2'b11
   } adj_e;

endpackage

// File: rtl/rate_fifo_wptr.sv
module rate_fifo_wptr #(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] pos
);

   // free-running: one entry per slow cycle, no gating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos <= '0;
      else        pos <= pos + AW'(1);
   end

endmodule

// File: rtl/rate_fifo_rptr.sv
module rate_fifo_rptr
   import rate_fifo_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int OFFSET = 4,
   localparam int AW = $clog2(DEPTH),
   localparam logic [AW-1:0] INIT = AW'(DEPTH - OFFSET)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [1:0]    adj,
   output logic [AW-1:0] pos,
   output logic [AW-1:0] pos_nxt
);

   adj_e          cmd;
   logic [AW-1:0] base;

   assign cmd  = adj_e'(adj);
   assign base = pos + AW'(step);

   always_comb begin
      unique case (cmd)
         ADJ_SKIP: pos_nxt = base + AW'(1);
         ADJ_SLIP: pos_nxt = base - AW'(1);
         default:  pos_nxt = base;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos <= INIT;
      else        pos <= pos_nxt;
   end

endmodule

// File: rtl/rate_fifo_ram.sv
module rate_fifo_ram #(
   parameter int WIDTH   = 16,
   parameter int DEPTH   = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             wr_clk,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd_clk,
   input  logic             rd_rst_n,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      mem[waddr] <= wdata;
   end

   generate
      if (OUT_REG) begin : g_reg
         // raddr is the position the reader holds after this edge
         always_ff @(posedge rd_clk or negedge rd_rst_n) begin
            if (!rd_rst_n) rdata <= '0;
            else           rdata <= mem[raddr];
         end
      end else begin : g_comb
         assign rdata = mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/rate_fifo.sv
module rate_fifo #(
   parameter int WIDTH   = 16,
   parameter int DEPTH   = 8,
   parameter int OFFSET  = 4,
   parameter bit OUT_REG = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             wr_clk,
   input  logic             wr_rst_n,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_clk,
   input  logic             rd_rst_n,
   input  logic             rd_step,
   input  logic [1:0]       rd_adj,
   output logic [WIDTH-1:0] rd_data,
   output logic [AW-1:0]    rd_pos
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rate_fifo: DEPTH must be a power of two and at least 2");
      end
      if (OFFSET < 1 || OFFSET >= DEPTH) begin : g_bad_offset
         $error("rate_fifo: OFFSET must lie in 1..DEPTH-1");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("rate_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [AW-1:0] wpos;
   logic [AW-1:0] rpos_nxt;
   logic [AW-1:0] raddr;

   rate_fifo_wptr #(.DEPTH(DEPTH)) u_wptr (
      .clk   (wr_clk),
      .rst_n (wr_rst_n),
      .pos   (wpos)
   );

   rate_fifo_rptr #(.DEPTH(DEPTH), .OFFSET(OFFSET)) u_rptr (
      .clk     (rd_clk),
      .rst_n   (rd_rst_n),
      .step    (rd_step),
      .adj     (rd_adj),
      .pos     (rd_pos),
      .pos_nxt (rpos_nxt)
   );

   assign raddr = OUT_REG ? rpos_nxt : rd_pos;

   rate_fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .OUT_REG(OUT_REG)) u_ram (
      .wr_clk   (wr_clk),
      .waddr    (wpos),
      .wdata    (wr_data),
      .rd_clk   (rd_clk),
      .rd_rst_n (rd_rst_n),
      .raddr    (raddr),
      .rdata    (rd_data)
   );

endmodule

// File: rtl/rate_fifo_chk.sv
module rate_fifo_chk #(
   parameter int DEPTH  = 8,
   parameter int OFFSET = 4,
   localparam int AW = $clog2(DEPTH),
   localparam logic [AW-1:0] INIT = AW'(DEPTH - OFFSET)
) (
   input logic          rd_clk,
   input logic          rd_rst_n,
   input logic          rd_step,
   input logic [1:0]    rd_adj,
   input logic [AW-1:0] rd_pos
);

   // R1: placement behind the writer while reset is held
   a_r1_reset_place: assert property (@(posedge rd_clk)
      !rd_rst_n |=> rd_pos == INIT);

   // R3: plain step
   a_r3_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_step && rd_adj == 2'b00) |=> rd_pos == AW'($past(rd_pos) + 1));

   // R4: hold without qualifier
   a_r4_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (!rd_step && rd_adj == 2'b00) |=> $stable(rd_pos));

   // R5: skip adds one entry
   a_r5_skip: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_adj == 2'b01) |=>
         rd_pos == AW'($past(rd_pos) + 1 + AW'($past(rd_step))));

   // R6: slip removes one entry
   a_r6_slip_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_adj == 2'b10 && rd_step) |=> $stable(rd_pos));
   a_r6_slip_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_adj == 2'b10 && !rd_step) |=> rd_pos == AW'($past(rd_pos) - 1));

   // R7: reserved code acts as no adjust
   a_r7_rsvd: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_adj == 2'b11) |=>
         rd_pos == AW'($past(rd_pos) + AW'($past(rd_step))));

endmodule

bind rate_fifo rate_fifo_chk #(.DEPTH(DEPTH), .OFFSET(OFFSET)) u_chk (
   .rd_clk   (rd_clk),
   .rd_rst_n (rd_rst_n),
   .rd_step  (rd_step),
   .rd_adj   (rd_adj),
   .rd_pos   (rd_pos)
);

// File: tb/rate_fifo_tb.sv
`timescale 1ns/1ps
module rate_fifo_tb;

   localparam int W = 16;
   localparam int D = 8;
   localparam int OFS = 4;

   logic         wr_clk = 1'b0;
   logic         rd_clk = 1'b0;
   logic         wr_rst_n = 1'b0;
   logic         rd_rst_n = 1'b0;
   logic [W-1:0] wr_data = 16'h1000;
   logic         rd_step = 1'b0;
   logic [1:0]   rd_adj = 2'b00;
   logic [W-1:0] rd_data;
   logic [2:0]   rd_pos;

   rate_fifo #(.WIDTH(W), .DEPTH(D), .OFFSET(OFS)) u_dut (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_step(rd_step),
      .rd_adj(rd_adj), .rd_data(rd_data), .rd_pos(rd_pos)
   );

   // 200 MHz fast clock: rising edges at 2.5 + 5n
   always #2.5 rd_clk = ~rd_clk;
   // slow clock, 3:2 ratio: rising edges at 4.75 + 7.5k, never on a fast edge
   initial begin
      #1;
      forever #3.75 wr_clk = ~wr_clk;
   end

   int nvec = 0;
   int nerr = 0;

   // independent model of the storage
   logic [W-1:0] shadow [D];
   logic [D-1:0] filled = '0;
   logic [2:0]   wslot = 3'd0;
   logic [2:0]   exp_pos = 3'd4;
   int           pidx = 0;
   localparam logic [11:0] IRREG = 12'b1010_1110_1110;

   always @(posedge wr_clk) begin
      if (wr_rst_n) begin
         shadow[wslot] = wr_data;
         filled[wslot] = 1'b1;
         wslot = wslot + 3'd1;
      end
   end

   always @(negedge wr_clk) wr_data <= wr_data + 16'h0013;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one fast cycle: drive at a falling edge, check at the next falling edge
   task automatic step(input logic adv, input logic [1:0] adj, input string req);
      logic [2:0] nx;
      rd_step = adv;
      rd_adj  = adj;
      nx = exp_pos + 3'(adv);
      if (adj == 2'b01) nx = nx + 3'd1;
      if (adj == 2'b10) nx = nx - 3'd1;
      @(posedge rd_clk);
      @(negedge rd_clk);
      exp_pos = nx;
      chk(rd_pos == exp_pos, req, 32'(rd_pos), 32'(exp_pos));
      if (filled[exp_pos])
         chk(rd_data == shadow[exp_pos], "R2/R8 data", 32'(rd_data),
             32'(shadow[exp_pos]));
      rd_step = 1'b0;
      rd_adj  = 2'b00;
   endtask

   function automatic logic pat_adv();
      return (pidx % 3) != 2;
   endfunction

   task automatic pat_step(input logic [1:0] adj, input string req);
      logic a;
      a = pat_adv();
      pidx++;
      step(a, adj, req);
   endtask

   task automatic t_reset;
      wr_rst_n = 1'b0;
      rd_rst_n = 1'b0;
      repeat (3) @(negedge rd_clk);
      chk(rd_pos == 3'd4, "R1 pos in reset", 32'(rd_pos), 32'd4);
      chk(rd_data == '0, "R1 data in reset", 32'(rd_data), 32'd0);
      wr_rst_n = 1'b1;
      rd_rst_n = 1'b1;
      #1;
      chk(rd_pos == 3'd4, "R1 pos after release", 32'(rd_pos), 32'd4);
      exp_pos = 3'd4;
   endtask

   task automatic t_regular;
      for (int i = 0; i < 36; i++) begin
         if (pat_adv()) pat_step(2'b00, "R3 step");
         else           pat_step(2'b00, "R4 hold");
      end
   endtask

   task automatic t_irregular;
      for (int i = 0; i < 24; i++) begin
         logic a;
         a = IRREG[i % 12];
         step(a, 2'b00, a ? "R3 irregular step" : "R4 irregular hold");
      end
   endtask

   task automatic t_reserved;
      step(1'b1, 2'b11, "R7 reserved with step");
      step(1'b0, 2'b11, "R7 reserved without step");
      step(1'b1, 2'b00, "R3 step");
   endtask

   task automatic t_adjust;
      step(1'b1, 2'b01, "R5 skip with step");
      step(1'b1, 2'b10, "R6 slip with step");
      step(1'b0, 2'b01, "R5 skip without step");
      step(1'b0, 2'b10, "R6 slip without step");
      pat_step(2'b00, "R3 step");
   endtask

   task automatic t_wrap_slip;
      // move the reader two ahead, then slip across 0 -> 7
      step(1'b1, 2'b01, "R5 skip with step");
      step(1'b1, 2'b01, "R5 skip with step");
      for (int i = 0; i < 40; i++) begin
         if (exp_pos == 3'd0) begin
            step(1'b0, 2'b10, "R6 slip wrap 0 to 7");
            chk(rd_pos == 3'd7, "R6 wrap value", 32'(rd_pos), 32'd7);
            break;
         end
         pat_step(2'b00, "R3 step");
      end
      for (int i = 0; i < 12; i++) pat_step(2'b00, "R3 step after wrap");
   endtask

   initial begin
      #1;
      t_reset();
      t_regular();
      t_irregular();
      t_reserved();
      t_adjust();
      t_wrap_slip();
      t_regular();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      #1000000;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule